// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and error pulses from a set of transmit and receive queue engines into sticky status words that a simple register port can read, and it drives a single level interrupt. Each direction has one queue per endpoint. Endpoint 0 has no queue, so its bits are held at zero everywhere. Completion pulses land in one word. Transmit endpoints fill the lower half of that word and receive endpoints fill the upper half. Error pulses land in three separate words: transmit checksum and length errors, receive checksum and length errors, and receive zero-length errors.

Every error word has a matching enable word, and only an enabled endpoint records an error event. A read-only summary word reduces the enabled error bits into five typed flags. The interrupt is the registered OR of every done bit allowed by its enable and every summary flag allowed by the summary enable. Software clears status by writing ones. An event that arrives in the same cycle as the clear wins, so no completion is lost.

Top module: `qirq_aggregator`

## Requirements
- R1: After reset every status word, enable word and the summary read zero, and `irq_o` is low.
- R2: Address 0 is the done word. A transmit done pulse on endpoint n sets bit n. A receive done pulse on endpoint n sets bit n+16 (NUM_EP=16). Done pulses are recorded whatever the done enable holds.
- R3: Writing a 1 to a bit of a status word (address 0, 2, 4 or 6) clears that bit. Writing a 0 leaves the bit unchanged.
- R4: A pulse that arrives in the same cycle as a write-one clear of the same bit leaves that bit set.
- R5: Endpoint 0 positions (bits 0 and 16) always read zero in every status word and every enable word, and endpoint 0 pulses are ignored.
- R6: Address 2 holds transmit checksum errors in bits [15:0] and transmit length errors in bits [31:16]. Address 4 holds the receive checksum and length errors in the same layout. Address 6 holds receive zero-length errors in bits [15:0], and its bits [31:16] read zero. The enable for each word sits at the next address (3, 5, 7). An error pulse sets its bit only while the matching enable bit is 1.
- R7: Error bits stay set until cleared by a write of one, including after their enable bit is later cleared.
- R8: Address 8 is a read-only summary. Bit 0 is receive checksum, bit 1 is receive length, bit 2 is receive zero-length, bit 3 is transmit checksum and bit 4 is transmit length. Each is the OR of the matching error bits whose enable bit is currently 1. Bits [31:5] read zero.
- R9: Address 9 holds the 5-bit summary enable. Address 1 holds the done enable. `irq_o` goes high one clock after any done bit is set with its enable set, or any summary bit is set with its enable set. It is low one clock after neither condition holds.
- R10: Enable words read back the value last written, with the endpoint 0 positions forced to zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done_ev | input | NUM_EP | Per-endpoint transmit completion pulse |
| rx_done_ev | input | NUM_EP | Per-endpoint receive completion pulse |
| tx_cs_ev | input | NUM_EP | Per-endpoint transmit checksum error pulse |
| tx_len_ev | input | NUM_EP | Per-endpoint transmit length error pulse |
| rx_cs_ev | input | NUM_EP | Per-endpoint receive checksum error pulse |
| rx_len_ev | input | NUM_EP | Per-endpoint receive length error pulse |
| rx_zlp_ev | input | NUM_EP | Per-endpoint receive zero-length pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 2*NUM_EP | Write data |
| rdata | output | 2*NUM_EP | Read data for `addr`, combinational from register state |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives an endpoint 0 pulse together with a real endpoint, and a design that failed to tie endpoint 0 would show an extra bit in both halves. It issues a clear together with a new pulse on the same bit, where a design that gave the clear priority would lose the completion. It fires error pulses with enables off, and then turns an enable off after a bit has latched. A design that recorded unenabled errors, or that dropped a sticky bit when its enable changed, shows the wrong status or summary value. Zero writes and mismatched done enables check that the interrupt stays low when nothing enabled is pending, and that it rises exactly one clock after an enabled bit is set.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int ADDR_W    = 4;
    localparam int SUM_W     = 5;
    localparam int NUM_BANKS = 4;

    // Register word addresses. A sticky status word sits at an even
    // address and its enable word at the next odd address.
    typedef enum logic [ADDR_W-1:0] {
        A_DONE     = 4'd0,
        A_DONE_EN  = 4'd1,
        A_TXERR    = 4'd2,
        A_TXERR_EN = 4'd3,
        A_RXERR    = 4'd4,
        A_RXERR_EN = 4'd5,
        A_ZLP      = 4'd6,
        A_ZLP_EN   = 4'd7,
        A_SUM      = 4'd8,
        A_SUM_EN   = 4'd9
    } reg_addr_e;

    // Summary bit positions
    localparam int S_RX_CS  = 0;
    localparam int S_RX_LEN = 1;
    localparam int S_RX_ZLP = 2;
    localparam int S_TX_CS  = 3;
    localparam int S_TX_LEN = 4;

endpackage

// File: rtl/qirq_sticky.sv
// Sticky status word: events set bits (when allowed), write-one clears,
// and a set in the same cycle as a clear wins.
module qirq_sticky #(
    parameter int          W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] rec_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = ((st_q.bits & ~clr) | (ev & rec_en)) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bits;

endmodule

// File: rtl/qirq_summary.sv
// Reduces enabled per-endpoint error bits into typed summary flags.
module qirq_summary
    import qirq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int WORD  = 2 * NUM_EP
) (
    input  logic [WORD-1:0]   txe,
    input  logic [WORD-1:0]   txe_en,
    input  logic [WORD-1:0]   rxe,
    input  logic [WORD-1:0]   rxe_en,
    input  logic [NUM_EP-1:0] zlp,
    input  logic [NUM_EP-1:0] zlp_en,
    output logic [SUM_W-1:0]  sum
);

    logic [WORD-1:0] txe_live;
    logic [WORD-1:0] rxe_live;

    always_comb begin
        txe_live      = txe & txe_en;
        rxe_live      = rxe & rxe_en;
        sum           = '0;
        sum[S_RX_CS]  = |rxe_live[NUM_EP-1:0];
        sum[S_RX_LEN] = |rxe_live[WORD-1:NUM_EP];
        sum[S_RX_ZLP] = |(zlp & zlp_en);
        sum[S_TX_CS]  = |txe_live[NUM_EP-1:0];
        sum[S_TX_LEN] = |txe_live[WORD-1:NUM_EP];
    end

endmodule

// File: rtl/qirq_aggregator.sv
module qirq_aggregator
    import qirq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int WORD  = 2 * NUM_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] tx_done_ev,
    input  logic [NUM_EP-1:0] rx_done_ev,
    input  logic [NUM_EP-1:0] tx_cs_ev,
    input  logic [NUM_EP-1:0] tx_len_ev,
    input  logic [NUM_EP-1:0] rx_cs_ev,
    input  logic [NUM_EP-1:0] rx_len_ev,
    input  logic [NUM_EP-1:0] rx_zlp_ev,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD-1:0]   wdata,
    output logic [WORD-1:0]   rdata,
    output logic              irq_o
);

    // Endpoint 0 has no queue: its position is held at zero in each half.
    localparam logic [NUM_EP-1:0] HALF_KEEP = {{(NUM_EP-1){1'b1}}, 1'b0};
    localparam logic [WORD-1:0]   FULL_KEEP = {HALF_KEEP, HALF_KEEP};
    localparam logic [WORD-1:0]   ZLP_KEEP  = {{NUM_EP{1'b0}}, HALF_KEEP};

    typedef struct packed {
        logic [WORD-1:0]  done_en;
        logic [WORD-1:0]  txe_en;
        logic [WORD-1:0]  rxe_en;
        logic [WORD-1:0]  zlp_en;
        logic [SUM_W-1:0] sum_en;
        logic             irq;
    } regs_t;

    regs_t st_d, st_q;

    logic [WORD-1:0]  bank_ev  [NUM_BANKS];
    logic [WORD-1:0]  bank_rec [NUM_BANKS];
    logic [WORD-1:0]  bank_q   [NUM_BANKS];
    logic [SUM_W-1:0] sum_w;

    // Signals observed by the bound checker
    logic [WORD-1:0]  done_w;
    logic [WORD-1:0]  done_en_w;
    logic [SUM_W-1:0] sum_en_w;

    // Bank 0: done, bank 1: tx errors, bank 2: rx errors, bank 3: rx zero-length
    assign bank_ev[0]  = {rx_done_ev, tx_done_ev};
    assign bank_ev[1]  = {tx_len_ev, tx_cs_ev};
    assign bank_ev[2]  = {rx_len_ev, rx_cs_ev};
    assign bank_ev[3]  = {{NUM_EP{1'b0}}, rx_zlp_ev};

    assign bank_rec[0] = FULL_KEEP;
    assign bank_rec[1] = st_q.txe_en;
    assign bank_rec[2] = st_q.rxe_en;
    assign bank_rec[3] = st_q.zlp_en;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [WORD-1:0] KEEP = (g == NUM_BANKS - 1) ? ZLP_KEEP : FULL_KEEP;
        logic [WORD-1:0] clr;

        assign clr = (wr_en && (addr == ADDR_W'(2 * g))) ? wdata : '0;

        qirq_sticky #(
            .W    (WORD),
            .KEEP (KEEP)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (bank_ev[g]),
            .rec_en (bank_rec[g]),
            .clr    (clr),
            .q      (bank_q[g])
        );
    end

    qirq_summary #(
        .NUM_EP (NUM_EP)
    ) u_summary (
        .txe    (bank_q[1]),
        .txe_en (st_q.txe_en),
        .rxe    (bank_q[2]),
        .rxe_en (st_q.rxe_en),
        .zlp    (bank_q[3][NUM_EP-1:0]),
        .zlp_en (st_q.zlp_en[NUM_EP-1:0]),
        .sum    (sum_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_DONE_EN:  st_d.done_en = wdata & FULL_KEEP;
                A_TXERR_EN: st_d.txe_en  = wdata & FULL_KEEP;
                A_RXERR_EN: st_d.rxe_en  = wdata & FULL_KEEP;
                A_ZLP_EN:   st_d.zlp_en  = wdata & ZLP_KEEP;
                A_SUM_EN:   st_d.sum_en  = wdata[SUM_W-1:0];
                default:    ;
            endcase
        end
        st_d.irq = (|(bank_q[0] & st_q.done_en)) | (|(sum_w & st_q.sum_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DONE:     rdata = bank_q[0];
            A_DONE_EN:  rdata = st_q.done_en;
            A_TXERR:    rdata = bank_q[1];
            A_TXERR_EN: rdata = st_q.txe_en;
            A_RXERR:    rdata = bank_q[2];
            A_RXERR_EN: rdata = st_q.rxe_en;
            A_ZLP:      rdata = bank_q[3];
            A_ZLP_EN:   rdata = st_q.zlp_en;
            A_SUM:      rdata = WORD'(sum_w);
            A_SUM_EN:   rdata = WORD'(st_q.sum_en);
            default:    rdata = '0;
        endcase
    end

    assign irq_o     = st_q.irq;
    assign done_w    = bank_q[0];
    assign done_en_w = st_q.done_en;
    assign sum_en_w  = st_q.sum_en;

endmodule

// File: rtl/qirq_aggregator_chk.sv
module qirq_aggregator_chk
    import qirq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int WORD  = 2 * NUM_EP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD-1:0]   wdata,
    input logic [NUM_EP-1:0] tx_done_ev,
    input logic [NUM_EP-1:0] rx_done_ev,
    input logic [WORD-1:0]   done_w,
    input logic [WORD-1:0]   done_en_w,
    input logic [SUM_W-1:0]  sum_w,
    input logic [SUM_W-1:0]  sum_en_w,
    input logic              irq_o
);

    // R5: endpoint 0 positions of the done word stay clear
    p_ep0_tied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_ev[0] || rx_done_ev[0]) |=> (!done_w[0] && !done_w[NUM_EP]));

    // R4: a done pulse is kept even if a clear hits the same bit
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_ev[1] |=> done_w[1]);

    // R3: write-one clears a bit when no pulse arrives with it
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DONE && wdata[1] && !tx_done_ev[1]) |=> !done_w[1]);

    // R3: writing zeros leaves the done word untouched
    p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DONE && wdata == '0 && tx_done_ev == '0 && rx_done_ev == '0)
        |=> $stable(done_w));

    // R9: an enabled pending done bit raises the interrupt next cycle
    p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_w & done_en_w) != '0) |=> irq_o);

    // R9: an enabled summary flag raises the interrupt next cycle
    p_irq_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_w & sum_en_w) != '0) |=> irq_o);

    // R9: nothing enabled pending means the interrupt drops next cycle
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((done_w & done_en_w) == '0) && ((sum_w & sum_en_w) == '0)) |=> !irq_o);

endmodule

bind qirq_aggregator qirq_aggregator_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .tx_done_ev (tx_done_ev),
    .rx_done_ev (rx_done_ev),
    .done_w     (done_w),
    .done_en_w  (done_en_w),
    .sum_w      (sum_w),
    .sum_en_w   (sum_en_w),
    .irq_o      (irq_o)
);

// File: tb/sim_qirq_aggregator.sv
module sim_qirq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP     = 16;
    localparam int WORD       = 2 * NUM_EP;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_EV  = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [3:0]  adr;
        logic [31:0] dat;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 46;
    // EV op: adr selects bus (0 tx_done,1 rx_done,2 tx_cs,3 tx_len,4 rx_cs,5 rx_len,6 rx_zlp)
    localparam vec_t TBL [NV] = '{
        '{OP_WR,  4'd10, 4'd1,  32'h0000_0002, 32'h0},           // R10 done enable ep1
        '{OP_RD,  4'd10, 4'd1,  32'h0,         32'h0000_0002},
        '{OP_EV,  4'd2,  4'd0,  32'h0000_0003, 32'h0},           // tx done ep0+ep1
        '{OP_RD,  4'd5,  4'd0,  32'h0,         32'h0000_0002},   // R2 R5
        '{OP_IRQ, 4'd9,  4'd0,  32'h0,         32'h1},           // R9
        '{OP_EV,  4'd2,  4'd1,  32'h0000_8001, 32'h0},           // rx done ep0+ep15
        '{OP_RD,  4'd2,  4'd0,  32'h0,         32'h8000_0002},   // R2
        '{OP_WR,  4'd3,  4'd0,  32'h0,         32'h0},           // R3 zero write
        '{OP_RD,  4'd3,  4'd0,  32'h0,         32'h8000_0002},
        '{OP_WR,  4'd3,  4'd0,  32'h0000_0002, 32'h0},           // R3 clear ep1
        '{OP_RD,  4'd3,  4'd0,  32'h0,         32'h8000_0000},
        '{OP_IRQ, 4'd9,  4'd0,  32'h0,         32'h0},           // R9 done not enabled
        '{OP_WR,  4'd3,  4'd0,  32'h8000_0000, 32'h0},
        '{OP_RD,  4'd3,  4'd0,  32'h0,         32'h0},
        '{OP_EV,  4'd6,  4'd2,  32'h0000_0004, 32'h0},           // tx cs, enable off
        '{OP_RD,  4'd6,  4'd2,  32'h0,         32'h0},           // R6
        '{OP_WR,  4'd10, 4'd3,  32'hFFFF_FFFF, 32'h0},
        '{OP_RD,  4'd10, 4'd3,  32'h0,         32'hFFFE_FFFE},   // R10 R5
        '{OP_EV,  4'd6,  4'd2,  32'h0000_0005, 32'h0},
        '{OP_EV,  4'd6,  4'd3,  32'h0000_0010, 32'h0},
        '{OP_RD,  4'd6,  4'd2,  32'h0,         32'h0010_0004},   // R6
        '{OP_RD,  4'd8,  4'd8,  32'h0,         32'h0000_0018},   // R8
        '{OP_IRQ, 4'd9,  4'd0,  32'h0,         32'h0},           // R9 summary not enabled
        '{OP_WR,  4'd9,  4'd9,  32'h0000_0008, 32'h0},
        '{OP_RD,  4'd10, 4'd9,  32'h0,         32'h0000_0008},
        '{OP_IRQ, 4'd9,  4'd0,  32'h0,         32'h1},           // R9 tx cs enabled
        '{OP_WR,  4'd7,  4'd2,  32'h0000_0004, 32'h0},           // R7 clear
        '{OP_RD,  4'd7,  4'd2,  32'h0,         32'h0010_0000},
        '{OP_RD,  4'd8,  4'd8,  32'h0,         32'h0000_0010},
        '{OP_IRQ, 4'd9,  4'd0,  32'h0,         32'h0},
        '{OP_WR,  4'd10, 4'd5,  32'h0003_0002, 32'h0},
        '{OP_WR,  4'd10, 4'd7,  32'hFFFF_FFFF, 32'h0},
        '{OP_RD,  4'd10, 4'd7,  32'h0,         32'h0000_FFFE},   // R10
        '{OP_EV,  4'd6,  4'd4,  32'h0000_0006, 32'h0},
        '{OP_EV,  4'd6,  4'd5,  32'h0000_0002, 32'h0},
        '{OP_EV,  4'd6,  4'd6,  32'h0000_8000, 32'h0},
        '{OP_RD,  4'd6,  4'd4,  32'h0,         32'h0002_0002},   // R6
        '{OP_RD,  4'd6,  4'd6,  32'h0,         32'h0000_8000},
        '{OP_RD,  4'd8,  4'd8,  32'h0,         32'h0000_0017},   // R8
        '{OP_WR,  4'd7,  4'd6,  32'hFFFF_FFFF, 32'h0},
        '{OP_RD,  4'd7,  4'd6,  32'h0,         32'h0},
        '{OP_RD,  4'd8,  4'd8,  32'h0,         32'h0000_0013},
        '{OP_RD,  4'd10, 4'd15, 32'h0,         32'h0},           // R10 unmapped
        '{OP_WR,  4'd8,  4'd5,  32'h0002_0000, 32'h0},           // drop rx cs enable
        '{OP_RD,  4'd8,  4'd8,  32'h0,         32'h0000_0012},   // R8
        '{OP_RD,  4'd7,  4'd4,  32'h0,         32'h0002_0002}    // R7 sticky kept
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EP-1:0] tx_done_ev, rx_done_ev, tx_cs_ev, tx_len_ev;
    logic [NUM_EP-1:0] rx_cs_ev, rx_len_ev, rx_zlp_ev;
    logic              wr_en;
    logic [3:0]        addr;
    logic [WORD-1:0]   wdata;
    logic [WORD-1:0]   rdata;
    logic              irq_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qirq_aggregator #(.NUM_EP(NUM_EP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_done_ev(tx_done_ev), .rx_done_ev(rx_done_ev),
        .tx_cs_ev(tx_cs_ev), .tx_len_ev(tx_len_ev),
        .rx_cs_ev(rx_cs_ev), .rx_len_ev(rx_len_ev), .rx_zlp_ev(rx_zlp_ev),
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o)
    );

    task automatic idle();
        tx_done_ev = '0; rx_done_ev = '0; tx_cs_ev = '0; tx_len_ev = '0;
        rx_cs_ev = '0; rx_len_ev = '0; rx_zlp_ev = '0;
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input int req, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp, $sformatf("read addr %0d", a));
    endtask

    task automatic drive_ev(input logic [3:0] sel, input logic [15:0] bits);
        case (sel)
            4'd0: tx_done_ev = bits;
            4'd1: rx_done_ev = bits;
            4'd2: tx_cs_ev   = bits;
            4'd3: tx_len_ev  = bits;
            4'd4: rx_cs_ev   = bits;
            4'd5: rx_len_ev  = bits;
            default: rx_zlp_ev = bits;
        endcase
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of every register and the interrupt
        for (int a = 0; a < 10; a++) rd_chk(1, 4'(a), 32'h0);
        chk(1, {31'b0, irq_o}, 32'h0, "irq after reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            case (TBL[i].op)
                OP_WR: begin
                    wr_en = 1'b1; addr = TBL[i].adr; wdata = TBL[i].dat;
                end
                OP_EV:  drive_ev(TBL[i].adr, TBL[i].dat[15:0]);
                OP_RD:  rd_chk(int'(TBL[i].req), TBL[i].adr, TBL[i].exp);
                default: chk(int'(TBL[i].req), {31'b0, irq_o}, TBL[i].exp, "irq level");
            endcase
        end

        // R4: done pulse and write-one clear on the same bit in one cycle
        @(negedge clk); idle();
        tx_done_ev = 16'h0008; wr_en = 1'b1; addr = 4'd0; wdata = 32'h0000_0008;
        @(negedge clk); idle();
        rd_chk(4, 4'd0, 32'h0000_0008);
        wr_en = 1'b1; addr = 4'd0; wdata = 32'h0000_0008;
        @(negedge clk); idle();
        rd_chk(3, 4'd0, 32'h0);

        // R4: same race on an enabled receive length error bit (bit 17)
        rx_len_ev = 16'h0002; wr_en = 1'b1; addr = 4'd4; wdata = 32'h0002_0000;
        @(negedge clk); idle();
        rd_chk(4, 4'd4, 32'h0002_0002);
        wr_en = 1'b1; addr = 4'd4; wdata = 32'hFFFF_FFFF;
        @(negedge clk); idle();
        rd_chk(7, 4'd4, 32'h0);

        // R5: endpoint 0 only pulses change nothing
        tx_done_ev = 16'h0001; rx_done_ev = 16'h0001; tx_len_ev = 16'h0001;
        @(negedge clk); idle();
        rd_chk(5, 4'd0, 32'h0);
        rd_chk(5, 4'd2, 32'h0010_0000);

        // R9: enabled done bit raises irq exactly one clock after it sets
        rx_done_ev = 16'h0004;
        @(negedge clk); idle();
        wr_en = 1'b1; addr = 4'd1; wdata = 32'h0004_0000;
        @(negedge clk); idle();
        chk(9, {31'b0, irq_o}, 32'h0, "irq before enable takes effect");
        @(negedge clk);
        chk(9, {31'b0, irq_o}, 32'h1, "irq with enabled rx done");

        // R1: reset mid-run returns everything to zero
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 10; a++) rd_chk(1, 4'(a), 32'h0);
        chk(1, {31'b0, irq_o}, 32'h0, "irq after second reset");

        finish_run();
    end

endmodule